// File: doc/BRIEF.md
# Temperature Conversion Scheduler

This block decides when a temperature converter runs and keeps the latest reading. After reset it launches a conversion at once. It then repeats conversions at one of four rates, each counted in ticks of an external time base. A conversion is started with a one-cycle start pulse. It ends when the converter returns a one-cycle done pulse together with a signed 13-bit sample, where one LSB is 0.0625 degrees C. Each accepted sample replaces the stored reading, and a one-cycle compare strobe tells downstream alert logic that a fresh value is available.

Setting the shutdown input does not cut off a conversion that is already running. That conversion finishes and is stored, and only then does the block go quiet. While quiet, a one-shot write launches exactly one conversion. The one-shot status output is low while that conversion runs and high once the block is back at rest. The stored word is formatted at the moment the sample is accepted. In normal format the sample is clamped to 12 bits and left-justified with four zero bits below it. In extended format all 13 bits are left-justified and bit 0 is set as a format marker.

Top module: `tempConvSched`

## Requirements
- R1: While reset is asserted and until the first result is stored, tempWord reads 0 and oneShotStat reads 0. adcStart is high in the first cycle after reset is released.
- R2: adcStart is never high for two cycles in a row. No new start is issued until the converter has returned done for the previous start.
- R3: In continuous operation, a launch is issued one cycle after the first clock edge at which the block is idle and the number of ticks counted since the previous launch has reached the period selected by rateSel. The periods are: 00 gives RATE0_TICKS (slowest), 01 gives RATE1_TICKS, 10 gives RATE2_TICKS and 11 gives RATE3_TICKS (fastest). Ticks are counted on clock edges where tick is high, starting after the launch edge.
- R4: An adcDone pulse accepted during a conversion updates tempWord in the next cycle, and cmpStrobe is high for exactly that one cycle. At all other times tempWord holds its value.
- R5: With extMode low at the done edge, tempWord is {clamped 12-bit sample, 4'b0000}. A sample above +2047 becomes 12'h7FF and a sample below -2048 becomes 12'h800. For example, 13'h0960 gives 16'h7FF0 and 13'h1000 gives 16'h8000.
- R6: With extMode high at the done edge, tempWord is {13-bit sample, 2'b00, 1'b1}. For example, 13'h0960 gives 16'h4B01.
- R7: If shutdownEn is high when a conversion ends, that result is still stored. oneShotStat then reads 1 and no further start is issued while shutdownEn stays high and no one-shot write arrives.
- R8: A oneShotWr pulse while oneShotStat is 1 and shutdownEn is high causes adcStart and oneShotStat = 0 in the next cycle. When that result is stored, oneShotStat returns to 1 and no further conversion follows.
- R9: A oneShotWr pulse while oneShotStat is 0 has no effect: it issues no start and does not change the continuous schedule.
- R10: Clearing shutdownEn while oneShotStat is 1 issues adcStart in the next cycle and resumes continuous operation.
- R11: An adcDone pulse that arrives while no conversion is running is ignored: tempWord is unchanged and cmpStrobe stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset, also used for a general-call reset |
| rateSel | input | 2 | Conversion rate select |
| shutdownEn | input | 1 | Stop converting after the conversion in flight |
| oneShotWr | input | 1 | One-cycle write of 1 to the one-shot control |
| extMode | input | 1 | 1 selects the 13-bit extended format |
| tick | input | 1 | Time-base tick, one cycle wide |
| adcDone | input | 1 | Converter finished, sample valid |
| adcSample | input | 13 | Signed converter result, 0.0625 degrees C per LSB |
| adcStart | output | 1 | One-cycle conversion start |
| tempWord | output | 16 | Formatted temperature word |
| oneShotStat | output | 1 | 1 when shut down and at rest |
| cmpStrobe | output | 1 | One-cycle pulse when a new result is stored |

## Verification
A control sequencer stuck in the wrong phase shows up within one cycle. It appears either as a missing or extra adcStart, or as oneShotStat disagreeing with the reference, for example when a one-shot write is honoured during continuous operation. A wrong tick count or period decode only shows as a launch that comes early or late, so it appears one full period after the previous start. A formatting or storage fault appears in the cycle of cmpStrobe, as a wrong clamp, a wrong shift or a missing format marker in tempWord.

// File: rtl/tempSchedPkg.sv
package tempSchedPkg;

  typedef enum logic [1:0] {
    PH_BOOT,
    PH_CONV,
    PH_WAIT,
    PH_SHUT
  } phase_t;

  // strobes from the sequencer to the result datapath
  typedef struct packed {
    logic store;
    logic extSel;
  } dpStrobe_t;

endpackage

// File: rtl/tempSchedCtrl.sv
module tempSchedCtrl
  import tempSchedPkg::*;
#(
  parameter int unsigned RATE0_TICKS = 4000,
  parameter int unsigned RATE1_TICKS = 1000,
  parameter int unsigned RATE2_TICKS = 250,
  parameter int unsigned RATE3_TICKS = 125,
  parameter int unsigned CNT_W       = 12
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [1:0] rateSel,
  input  logic       shutdownEn,
  input  logic       oneShotWr,
  input  logic       extMode,
  input  logic       tick,
  input  logic       adcDone,
  output logic       adcStart,
  output logic       oneShotStat,
  output dpStrobe_t  strobe
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  phase_t           phase, phaseNext;
  logic [CNT_W-1:0] tickCnt;
  logic [CNT_W-1:0] periodSel;
  logic             launch;
  logic             counting;

  always_comb begin
    case (rateSel)
      2'b00:   periodSel = CNT_W'(RATE0_TICKS);
      2'b01:   periodSel = CNT_W'(RATE1_TICKS);
      2'b10:   periodSel = CNT_W'(RATE2_TICKS);
      default: periodSel = CNT_W'(RATE3_TICKS);
    endcase
  end

  always_comb begin
    launch    = 1'b0;
    phaseNext = phase;
    case (phase)
      PH_BOOT: launch = 1'b1;
      PH_CONV: if (adcDone) phaseNext = shutdownEn ? PH_SHUT : PH_WAIT;
      PH_WAIT: begin
        if (shutdownEn)               phaseNext = PH_SHUT;
        else if (tickCnt >= periodSel) launch   = 1'b1;
      end
      PH_SHUT: if (!shutdownEn || oneShotWr) launch = 1'b1;
      default: phaseNext = PH_BOOT;
    endcase
    if (launch) phaseNext = PH_CONV;
  end

  assign counting = tick && (phase == PH_CONV || phase == PH_WAIT) && (tickCnt != CNT_MAX);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase    <= PH_BOOT;
      adcStart <= 1'b0;
      tickCnt  <= '0;
    end else begin
      phase    <= phaseNext;
      adcStart <= launch;
      if (launch)        tickCnt <= '0;
      else if (counting) tickCnt <= tickCnt + 1'b1;
    end
  end

  assign oneShotStat   = (phase == PH_SHUT);
  assign strobe.store  = (phase == PH_CONV) && adcDone;
  assign strobe.extSel = extMode;

endmodule

// File: rtl/tempSchedData.sv
module tempSchedData
  import tempSchedPkg::*;
#(
  parameter int unsigned SAMPLE_W = 13,
  parameter int unsigned WORD_W   = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  dpStrobe_t           strobe,
  input  logic [SAMPLE_W-1:0] adcSample,
  output logic [WORD_W-1:0]   tempWord,
  output logic                cmpStrobe
);

  localparam int unsigned NORM_W   = SAMPLE_W - 1;
  localparam int unsigned NORM_PAD = WORD_W - NORM_W;
  localparam int unsigned EXT_PAD  = WORD_W - SAMPLE_W - 1;

  logic [NORM_W-1:0] clamped;
  logic              overflow;
  logic [WORD_W-1:0] normWord, extWord;

  // the top two sample bits disagree when the value leaves the 12-bit range
  assign overflow = adcSample[SAMPLE_W-1] ^ adcSample[SAMPLE_W-2];
  assign clamped  = overflow ? {adcSample[SAMPLE_W-1], {(NORM_W-1){~adcSample[SAMPLE_W-1]}}}
                             : adcSample[NORM_W-1:0];
  assign normWord = {clamped, {NORM_PAD{1'b0}}};
  assign extWord  = {adcSample, {EXT_PAD{1'b0}}, 1'b1};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tempWord  <= '0;
      cmpStrobe <= 1'b0;
    end else begin
      cmpStrobe <= strobe.store;
      if (strobe.store) tempWord <= strobe.extSel ? extWord : normWord;
    end
  end

endmodule

// File: rtl/tempConvSched.sv
module tempConvSched
  import tempSchedPkg::*;
#(
  parameter int unsigned RATE0_TICKS = 4000,
  parameter int unsigned RATE1_TICKS = 1000,
  parameter int unsigned RATE2_TICKS = 250,
  parameter int unsigned RATE3_TICKS = 125
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [1:0]  rateSel,
  input  logic        shutdownEn,
  input  logic        oneShotWr,
  input  logic        extMode,
  input  logic        tick,
  input  logic        adcDone,
  input  logic [12:0] adcSample,
  output logic        adcStart,
  output logic [15:0] tempWord,
  output logic        oneShotStat,
  output logic        cmpStrobe
);

  localparam int unsigned MAX01 = (RATE0_TICKS > RATE1_TICKS) ? RATE0_TICKS : RATE1_TICKS;
  localparam int unsigned MAX23 = (RATE2_TICKS > RATE3_TICKS) ? RATE2_TICKS : RATE3_TICKS;
  localparam int unsigned MAX_TICKS = (MAX01 > MAX23) ? MAX01 : MAX23;
  localparam int unsigned CNT_W = $clog2(MAX_TICKS + 2);

  dpStrobe_t strobe;

  tempSchedCtrl #(
    .RATE0_TICKS(RATE0_TICKS),
    .RATE1_TICKS(RATE1_TICKS),
    .RATE2_TICKS(RATE2_TICKS),
    .RATE3_TICKS(RATE3_TICKS),
    .CNT_W      (CNT_W)
  ) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .rateSel    (rateSel),
    .shutdownEn (shutdownEn),
    .oneShotWr  (oneShotWr),
    .extMode    (extMode),
    .tick       (tick),
    .adcDone    (adcDone),
    .adcStart   (adcStart),
    .oneShotStat(oneShotStat),
    .strobe     (strobe)
  );

  tempSchedData #(
    .SAMPLE_W(13),
    .WORD_W  (16)
  ) u_data (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .adcSample(adcSample),
    .tempWord (tempWord),
    .cmpStrobe(cmpStrobe)
  );

endmodule

// File: rtl/tempConvSchedChk.sv
module tempConvSchedChk (
  input logic        clk,
  input logic        rstN,
  input logic        shutdownEn,
  input logic        oneShotWr,
  input logic        extMode,
  input logic        adcStart,
  input logic [15:0] tempWord,
  input logic        oneShotStat,
  input logic        cmpStrobe
);

  // R2
  start_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    adcStart |=> !adcStart);

  // R4
  strobe_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmpStrobe |=> !cmpStrobe);

  // R4
  word_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !cmpStrobe |-> $stable(tempWord));

  // R5
  norm_fmt_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cmpStrobe && !$past(extMode)) |-> (tempWord[3:0] == 4'h0));

  // R6
  ext_fmt_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cmpStrobe && $past(extMode)) |-> (tempWord[2:0] == 3'b001));

  // R7
  shut_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (oneShotStat && shutdownEn && !oneShotWr) |=> (!adcStart && oneShotStat));

  // R8
  shot_launch_chk: assert property (@(posedge clk) disable iff (!rstN)
    (oneShotStat && shutdownEn && oneShotWr) |=> (adcStart && !oneShotStat));

  // R10
  resume_chk: assert property (@(posedge clk) disable iff (!rstN)
    (oneShotStat && !shutdownEn) |=> adcStart);

endmodule

bind tempConvSched tempConvSchedChk u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .shutdownEn (shutdownEn),
  .oneShotWr  (oneShotWr),
  .extMode    (extMode),
  .adcStart   (adcStart),
  .tempWord   (tempWord),
  .oneShotStat(oneShotStat),
  .cmpStrobe  (cmpStrobe)
);

// File: tb/test_tempConvSched.sv
module test_tempConvSched;

  localparam int P0 = 40, P1 = 20, P2 = 10, P3 = 6;

  logic        clk = 0;
  logic        rstN = 0;
  logic [1:0]  rateSel = 2'b10;
  logic        shutdownEn = 0, oneShotWr = 0, extMode = 0, tick = 0;
  logic        modelDone = 0, spurDone = 0, adcDone;
  logic [12:0] adcSample = '0;
  logic        adcStart, oneShotStat, cmpStrobe;
  logic [15:0] tempWord;

  assign adcDone = modelDone | spurDone;

  tempConvSched #(.RATE0_TICKS(P0), .RATE1_TICKS(P1), .RATE2_TICKS(P2), .RATE3_TICKS(P3))
  i_tempConvSched (
    .clk(clk), .rstN(rstN), .rateSel(rateSel), .shutdownEn(shutdownEn),
    .oneShotWr(oneShotWr), .extMode(extMode), .tick(tick), .adcDone(adcDone),
    .adcSample(adcSample), .adcStart(adcStart), .tempWord(tempWord),
    .oneShotStat(oneShotStat), .cmpStrobe(cmpStrobe)
  );

  always #2.5 clk = ~clk;  // 200 MHz

  int checks = 0, errors = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int fmtWord(input int s13, input bit em);
    int v, c;
    v = (s13 >= 4096) ? s13 - 8192 : s13;
    if (em) return ((v & 8191) * 8) + 1;
    c = (v > 2047) ? 2047 : ((v < -2048) ? -2048 : v);
    return (c & 4095) * 16;
  endfunction

  // ---------------- converter model: done four negedges after start ----------
  int adcCnt = 0, sIdx = 0;
  int sampleList[8] = '{'h0960, 'h1E70, 'h1C90, 'h0190, 'h1FFC, 'h1000, 'h0004, 'h07FF};
  int tcnt = 0;
  bit tickOn = 1;
  bit inFlight = 0;

  always @(negedge clk) begin
    modelDone = 0;
    if (adcStart) adcCnt = 4;
    else if (adcCnt > 0) begin
      adcCnt--;
      if (adcCnt == 0) begin
        modelDone = 1;
        adcSample = 13'(sampleList[sIdx]);
        sIdx = (sIdx + 1) % 8;
      end
    end
    tcnt++;
    tick = tickOn && (tcnt % 2 == 0);
  end

  // ---------------- reference model, updated on every edge -------------------
  int  mPh = 0;          // 0 boot, 1 busy, 2 resting, 3 shut down
  int  mTicks = 0;
  int  expWord = 0;
  bit  expStart = 0, expCmp = 0, expStat = 0, started = 0;
  int  doneSample = 0;
  bit  doneEm = 0;
  int  cyc = 0;

  function automatic int periodOf(input logic [1:0] r);
    case (r)
      2'b00: return P0;
      2'b01: return P1;
      2'b10: return P2;
      default: return P3;
    endcase
  endfunction

  always @(posedge clk) begin
    bit go;
    cyc++;
    started = 1;
    if (!rstN) begin
      mPh = 0; mTicks = 0; expWord = 0; expStart = 0; expCmp = 0; expStat = 0;
    end else begin
      go = 0; expCmp = 0;
      if (mPh == 0) go = 1;
      else if (mPh == 1) begin
        if (tick) mTicks++;
        if (adcDone) begin
          expWord = fmtWord(int'(adcSample), extMode);
          doneSample = int'(adcSample); doneEm = extMode;
          expCmp = 1;
          mPh = shutdownEn ? 3 : 2;
        end
      end else if (mPh == 2) begin
        if (shutdownEn) mPh = 3;
        else if (mTicks >= periodOf(rateSel)) go = 1;
        else if (tick) mTicks++;
      end else begin
        if (!shutdownEn || oneShotWr) go = 1;
      end
      expStart = go;
      if (go) begin mPh = 1; mTicks = 0; end
      expStat = (mPh == 3);
    end
  end

  // ---------------- per-cycle comparison and directed format checks ----------
  always @(negedge clk) if (started && !done) begin
    chk(adcStart === expStart, "R3 adcStart", adcStart, expStart);
    chk(tempWord === 16'(expWord), "R4 tempWord", tempWord, expWord);
    chk(cmpStrobe === expCmp, "R4 cmpStrobe", cmpStrobe, expCmp);
    chk(oneShotStat === expStat, "R8 oneShotStat", oneShotStat, expStat);
    if (rstN) begin
      if (adcStart && inFlight) chk(0, "R2 start while busy", 1, 0);
      if (adcStart) inFlight = 1;
      if (cmpStrobe) inFlight = 0;
    end
    if (cmpStrobe && !doneEm) begin
      if (doneSample == 'h0960) chk(tempWord == 16'h7FF0, "R5 clamp high", tempWord, 'h7FF0);
      if (doneSample == 'h1000) chk(tempWord == 16'h8000, "R5 clamp low", tempWord, 'h8000);
      if (doneSample == 'h1E70) chk(tempWord == 16'hE700, "R5 negative", tempWord, 'hE700);
    end
    if (cmpStrobe && doneEm) begin
      if (doneSample == 'h0960) chk(tempWord == 16'h4B01, "R6 150C", tempWord, 'h4B01);
      if (doneSample == 'h1C90) chk(tempWord == 16'hE481, "R6 -55C", tempWord, 'hE481);
      if (doneSample == 'h1E70) chk(tempWord == 16'hF381, "R6 -25C", tempWord, 'hF381);
    end
  end

  task automatic waitStrobe();
    do @(negedge clk); while (!cmpStrobe);
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  always @(posedge clk) if (cyc > 100000) begin
    chk(0, "watchdog", cyc, 100000);
    finishRun();
  end

  // ---------------- stimulus ----------------
  initial begin
    int cnt;
    logic [15:0] held;
    repeat (4) @(negedge clk);
    chk(tempWord == 0, "R1 reset word", tempWord, 0);
    chk(oneShotStat == 0, "R1 reset stat", oneShotStat, 0);
    rstN = 1;
    @(negedge clk);
    chk(adcStart == 1, "R1 launch after reset", adcStart, 1);
    chk(tempWord == 0, "R1 word before first result", tempWord, 0);

    repeat (300) @(negedge clk);            // rate 10, normal format
    rateSel = 2'b11; repeat (200) @(negedge clk);
    extMode = 1;     repeat (250) @(negedge clk);
    rateSel = 2'b00; repeat (400) @(negedge clk);
    extMode = 0;     rateSel = 2'b01; repeat (300) @(negedge clk);

    // R9: one-shot write while running is ignored
    rateSel = 2'b11;
    repeat (20) @(negedge clk);
    waitStrobe();
    oneShotWr = 1;
    @(negedge clk);
    oneShotWr = 0;
    chk(adcStart == 0, "R9 no start", adcStart, 0);
    chk(oneShotStat == 0, "R9 stat", oneShotStat, 0);

    // R11: stray done while idle is ignored
    held = tempWord;
    spurDone = 1;
    @(negedge clk);
    spurDone = 0;
    chk(cmpStrobe == 0, "R11 no strobe", cmpStrobe, 0);
    chk(tempWord == held, "R11 word kept", tempWord, held);

    // R7: shutdown requested during a conversion
    do @(negedge clk); while (!adcStart);
    shutdownEn = 1;
    waitStrobe();
    chk(oneShotStat == 1, "R7 stat after last result", oneShotStat, 1);
    cnt = 0;
    repeat (120) begin @(negedge clk); if (adcStart) cnt++; end
    chk(cnt == 0, "R7 quiet", cnt, 0);

    // R8: one-shot from shutdown
    oneShotWr = 1;
    @(negedge clk);
    oneShotWr = 0;
    chk(adcStart == 1, "R8 start", adcStart, 1);
    chk(oneShotStat == 0, "R8 busy", oneShotStat, 0);
    waitStrobe();
    chk(oneShotStat == 1, "R8 ready", oneShotStat, 1);
    cnt = 0;
    repeat (80) begin @(negedge clk); if (adcStart) cnt++; end
    chk(cnt == 0, "R8 single conversion", cnt, 0);

    // R10: leave shutdown
    shutdownEn = 0;
    @(negedge clk);
    chk(adcStart == 1, "R10 resume", adcStart, 1);
    repeat (150) @(negedge clk);
    finishRun();
  end

endmodule